// File: doc/BRIEF.md
# Truncating Vector Immediate Compare Sequencer

This block walks a vector of integer registers, compares each element with a signed immediate, and writes one 4-bit condition field for every element it visits. It handles one element per clock. A start pulse launches a run, busy is high while elements are being processed, and a one-cycle done pulse marks the end. Each operand has its own flag that chooses whether it advances along the vector or stays fixed. One datapath therefore covers scalar-to-scalar, scalar-to-vector, vector-to-scalar and vector-to-vector forms.

In early-exit mode the sequencer applies a test to each freshly written condition field. The test picks one of the four field bits and a polarity. When an element fails the test, the run stops at that element and a shortened element count is reported. The count can either include the failing element or exclude it, and a count of zero is a legitimate result. With early exit off, every element is visited and the count comes back unchanged. The block reads registers through a combinational read port and writes condition fields through a write-enable port, so it sits directly beside existing register files.

Top module: `tvc_seq`

## Requirements
- R1: After synchronous reset, busy, done, cf_we, trunc are 0 and vl_out is 0.
- R2: The requested count vl_in is clamped to VLMAX (64). Without early exit, every clamped element is written, one per cycle. Done rises exactly n clock edges after the edge that sampled start, where n is the number of elements written. The outputs are vl_out equal to the clamped count and trunc equal to 0.
- R3: The written condition field holds bit3 = source < imm, bit2 = source > imm, bit1 = source == imm and bit0 = the so_in value captured at start. All compares are signed two's complement.
- R4: For element i, the read index is (src_base + i) mod NREG when src_vec is 1, and src_base otherwise.
- R5: For element i, the write index is (dst_base + i) mod NCF when dst_vec is 1, and dst_base otherwise. Fields that are not written keep their values.
- R6: An element fails when bit test_sel of its condition field equals test_pol (1 = fail when set, 0 = fail when clear). Failure has an effect only when ff_en is 1.
- R7: With ff_en=1 and ff_excl=0, the first failing element i is still written, no later element is written, vl_out = i+1 and trunc = 1.
- R8: With ff_en=1 and ff_excl=1, the failing element i is still written, no later element is written, vl_out = i and trunc = 1.
- R9: vl_in=0 produces done on the edge after start with no writes, vl_out=0 and trunc=0. An exclusive failure at element 0 produces vl_out=0 with trunc=1.
- R10: All configuration inputs are captured at start. Changing them, or pulsing start, while busy has no effect on the run.
- R11: done is a single-cycle pulse that never coincides with busy. vl_out and trunc hold their values until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run (accepted when not busy) |
| vl_in | input | VLW | Requested element count |
| src_base | input | RIW | First source register index |
| src_vec | input | 1 | Source advances per element |
| dst_base | input | CIW | First condition-field index |
| dst_vec | input | 1 | Destination advances per element |
| imm | input | XLEN | Signed immediate operand |
| so_in | input | 1 | Summary-overflow bit copied into bit0 |
| ff_en | input | 1 | Enable early exit on failure |
| ff_excl | input | 1 | Exclude the failing element from the count |
| test_sel | input | 2 | Condition-field bit to test |
| test_pol | input | 1 | Bit value that means failure |
| rd_idx | output | RIW | Register read index |
| rd_data | input | XLEN | Register read data (combinational) |
| cf_we | output | 1 | Condition-field write enable |
| cf_idx | output | CIW | Condition-field write index |
| cf_val | output | 4 | Condition-field write value |
| busy | output | 1 | Elements being processed |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW | Resulting element count |
| trunc | output | 1 | Run stopped early on a failure |

## Verification
A wrong element counter or a wrong stop decision shows up at the done edge. In that case the cycle count from start, the number of write strobes, or vl_out differs from the arithmetic model for that run. A corrupted index or a corrupted latched flag writes a field into the wrong slot, which shows as a mismatch in the shadow condition-field file at the end of the run, in the same run. A configuration that is not latched reveals itself because the bench scrambles every input right after start.

// File: rtl/tvc_pkg.sv
package tvc_pkg;

    localparam int CF_W = 4;

    // Condition field: bit3 less, bit2 greater, bit1 equal, bit0 overflow copy
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cf_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    function automatic logic cf_fails(input cf_t cf, input logic [1:0] sel, input logic pol);
        logic [CF_W-1:0] bits;
        bits = cf;
        return bits[sel] == pol;
    endfunction

endpackage

// File: rtl/tvc_cmp_unit.sv
module tvc_cmp_unit
    import tvc_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0] opnd,
    input  logic [XLEN-1:0] imm,
    input  logic            so,
    input  logic [1:0]      sel,
    input  logic            pol,
    output cf_t             cf,
    output logic            fail
);
    always_comb begin
        cf.lt = $signed(opnd) <  $signed(imm);
        cf.gt = $signed(opnd) >  $signed(imm);
        cf.eq = opnd == imm;
        cf.so = so;
        fail  = cf_fails(cf, sel, pol);
    end
endmodule

// File: rtl/tvc_index.sv
module tvc_index #(
    parameter int IW = 5,
    parameter int CW = 7
) (
    input  logic [IW-1:0] base,
    input  logic          vec,
    input  logic [CW-1:0] count,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] step;

    generate
        if (CW >= IW) begin : g_narrow
            assign step = count[IW-1:0];
            if (CW > IW) begin : g_drop
                logic unused_hi;
                assign unused_hi = ^count[CW-1:IW];
            end
        end else begin : g_wide
            assign step = {{(IW-CW){1'b0}}, count};
        end
    endgenerate

    assign idx = base + (vec ? step : '0);
endmodule

// File: rtl/tvc_seq.sv
module tvc_seq
    import tvc_pkg::*;
#(
    parameter int XLEN  = 16,
    parameter int NREG  = 32,
    parameter int NCF   = 8,
    parameter int VLMAX = 64,
    localparam int RIW  = $clog2(NREG),
    localparam int CIW  = $clog2(NCF),
    localparam int VLW  = $clog2(VLMAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VLW-1:0]  vl_in,
    input  logic [RIW-1:0]  src_base,
    input  logic            src_vec,
    input  logic [CIW-1:0]  dst_base,
    input  logic            dst_vec,
    input  logic [XLEN-1:0] imm,
    input  logic            so_in,
    input  logic            ff_en,
    input  logic            ff_excl,
    input  logic [1:0]      test_sel,
    input  logic            test_pol,
    output logic [RIW-1:0]  rd_idx,
    input  logic [XLEN-1:0] rd_data,
    output logic            cf_we,
    output logic [CIW-1:0]  cf_idx,
    output logic [3:0]      cf_val,
    output logic            busy,
    output logic            done,
    output logic [VLW-1:0]  vl_out,
    output logic            trunc
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(VLMAX);

    phase_t          phase;
    logic [VLW-1:0]  elem;
    logic [VLW-1:0]  vlc_q;
    logic [RIW-1:0]  sb_q;
    logic            sv_q;
    logic [CIW-1:0]  db_q;
    logic            dv_q;
    logic [XLEN-1:0] imm_q;
    logic            so_q;
    logic            ff_q;
    logic            ex_q;
    logic [1:0]      sel_q;
    logic            pol_q;

    logic [VLW-1:0]  vl_clamped;
    logic            accept;
    logic            last;
    logic            elem_fail;
    cf_t             cf_now;

    assign vl_clamped = (vl_in > VL_CAP) ? VL_CAP : vl_in;
    assign accept     = start && (phase != PH_RUN);
    assign last       = (elem == vlc_q - 1'b1);

    tvc_index #(.IW(RIW), .CW(VLW)) u_src_idx (
        .base (sb_q), .vec (sv_q), .count (elem), .idx (rd_idx)
    );

    tvc_index #(.IW(CIW), .CW(VLW)) u_dst_idx (
        .base (db_q), .vec (dv_q), .count (elem), .idx (cf_idx)
    );

    tvc_cmp_unit #(.XLEN(XLEN)) u_cmp (
        .opnd (rd_data), .imm (imm_q), .so (so_q),
        .sel  (sel_q),   .pol (pol_q),
        .cf   (cf_now),  .fail (elem_fail)
    );

    assign busy   = (phase == PH_RUN);
    assign done   = (phase == PH_DONE);
    assign cf_we  = busy;
    assign cf_val = cf_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            elem   <= '0;
            vlc_q  <= '0;
            sb_q   <= '0;
            sv_q   <= 1'b0;
            db_q   <= '0;
            dv_q   <= 1'b0;
            imm_q  <= '0;
            so_q   <= 1'b0;
            ff_q   <= 1'b0;
            ex_q   <= 1'b0;
            sel_q  <= '0;
            pol_q  <= 1'b0;
            vl_out <= '0;
            trunc  <= 1'b0;
        end else if (accept) begin
            elem  <= '0;
            vlc_q <= vl_clamped;
            sb_q  <= src_base;
            sv_q  <= src_vec;
            db_q  <= dst_base;
            dv_q  <= dst_vec;
            imm_q <= imm;
            so_q  <= so_in;
            ff_q  <= ff_en;
            ex_q  <= ff_excl;
            sel_q <= test_sel;
            pol_q <= test_pol;
            if (vl_clamped == '0) begin
                phase  <= PH_DONE;
                vl_out <= '0;
                trunc  <= 1'b0;
            end else begin
                phase <= PH_RUN;
            end
        end else begin
            case (phase)
                PH_RUN: begin
                    if (ff_q && elem_fail) begin
                        phase  <= PH_DONE;
                        vl_out <= ex_q ? elem : elem + 1'b1;
                        trunc  <= 1'b1;
                    end else if (last) begin
                        phase  <= PH_DONE;
                        vl_out <= vlc_q;
                        trunc  <= 1'b0;
                    end else begin
                        elem <= elem + 1'b1;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tvc_seq_chk.sv
module tvc_seq_chk #(
    parameter int RIW   = 5,
    parameter int CIW   = 3,
    parameter int VLW   = 7,
    parameter int VLMAX = 64
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           done,
    input logic           cf_we,
    input logic [CIW-1:0] cf_idx,
    input logic [RIW-1:0] rd_idx,
    input logic [VLW-1:0] vl_out,
    input logic           trunc,
    input logic           sv_q,
    input logic           dv_q,
    input logic           ff_q
);
    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: done and busy are exclusive
    a_r11_not_both: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R2: writes only happen while processing
    a_r2_we_in_run: assert property (@(posedge clk) disable iff (rst)
        cf_we |-> busy);

    // R2: reported count never exceeds the cap
    a_r2_vl_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (vl_out <= VLW'(VLMAX)));

    // R5: scalar destination stays put, vector destination steps by one
    a_r5_dst_scalar: assert property (@(posedge clk) disable iff (rst)
        (cf_we && $past(cf_we) && !dv_q) |-> (cf_idx == $past(cf_idx)));
    a_r5_dst_vector: assert property (@(posedge clk) disable iff (rst)
        (cf_we && $past(cf_we) && dv_q) |-> (cf_idx == CIW'($past(cf_idx) + 1'b1)));

    // R4: source index behaves the same way
    a_r4_src_scalar: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !sv_q) |-> (rd_idx == $past(rd_idx)));
    a_r4_src_vector: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && sv_q) |-> (rd_idx == RIW'($past(rd_idx) + 1'b1)));

    // R7: a truncated result only comes from early-exit mode
    a_r7_trunc_needs_ff: assert property (@(posedge clk) disable iff (rst)
        (done && trunc) |-> ff_q);
endmodule

bind tvc_seq tvc_seq_chk #(.RIW(RIW), .CIW(CIW), .VLW(VLW), .VLMAX(VLMAX)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .cf_we  (cf_we),
    .cf_idx (cf_idx),
    .rd_idx (rd_idx),
    .vl_out (vl_out),
    .trunc  (trunc),
    .sv_q   (sv_q),
    .dv_q   (dv_q),
    .ff_q   (ff_q)
);

// File: tb/tvc_seq_tb.sv
module tvc_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 16;
    localparam int NREG = 32;
    localparam int NCF  = 8;
    localparam int VLW  = 7;
    localparam int RIW  = 5;
    localparam int CIW  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [VLW-1:0]  vl_in = '0;
    logic [RIW-1:0]  src_base = '0;
    logic            src_vec = 1'b0;
    logic [CIW-1:0]  dst_base = '0;
    logic            dst_vec = 1'b0;
    logic [XLEN-1:0] imm = '0;
    logic            so_in = 1'b0;
    logic            ff_en = 1'b0;
    logic            ff_excl = 1'b0;
    logic [1:0]      test_sel = '0;
    logic            test_pol = 1'b0;
    logic [RIW-1:0]  rd_idx;
    logic [XLEN-1:0] rd_data;
    logic            cf_we;
    logic [CIW-1:0]  cf_idx;
    logic [3:0]      cf_val;
    logic            busy;
    logic            done;
    logic [VLW-1:0]  vl_out;
    logic            trunc;

    logic [XLEN-1:0] rf [NREG];
    logic [3:0]      cf_mem [NCF];
    logic [3:0]      exp_cf [NCF];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tvc_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl_in),
        .src_base(src_base), .src_vec(src_vec), .dst_base(dst_base), .dst_vec(dst_vec),
        .imm(imm), .so_in(so_in), .ff_en(ff_en), .ff_excl(ff_excl),
        .test_sel(test_sel), .test_pol(test_pol),
        .rd_idx(rd_idx), .rd_data(rd_data), .cf_we(cf_we), .cf_idx(cf_idx), .cf_val(cf_val),
        .busy(busy), .done(done), .vl_out(vl_out), .trunc(trunc)
    );

    assign rd_data = rf[rd_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int j = 0; j < NCF; j++) cf_mem[j] <= 4'(j * 3);
        end else if (cf_we) begin
            cf_mem[cf_idx] <= cf_val;
        end
    end

    task automatic check(input string req, input logic ok, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic run(input int vl, input int sb, input int sv, input int db, input int dv,
                       input int iv, input int so, input int ff, input int ex,
                       input int sel, input int pol, input int poke);
        int vc, nproc, evl, etr, cycles, writes, ridx, widx;
        logic signed [XLEN-1:0] s, im;
        logic [3:0] c;
        vc = (vl > 64) ? 64 : vl;
        nproc = 0; evl = vc; etr = 0;
        im = XLEN'(iv);
        for (int i = 0; i < vc; i++) begin
            ridx = (sb + ((sv != 0) ? i : 0)) % NREG;
            widx = (db + ((dv != 0) ? i : 0)) % NCF;
            s = rf[ridx];
            c = {s < im, s > im, s == im, 1'(so)};
            exp_cf[widx] = c;
            nproc++;
            if (ff != 0 && c[sel] == 1'(pol)) begin
                evl = (ex != 0) ? i : i + 1;
                etr = 1;
                break;
            end
        end

        @(negedge clk);
        vl_in = VLW'(vl); src_base = RIW'(sb); src_vec = 1'(sv);
        dst_base = CIW'(db); dst_vec = 1'(dv); imm = im; so_in = 1'(so);
        ff_en = 1'(ff); ff_excl = 1'(ex); test_sel = 2'(sel); test_pol = 1'(pol);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        // R10: scramble every configuration input after capture
        vl_in = ~vl_in; src_base = ~src_base; src_vec = ~src_vec;
        dst_base = ~dst_base; dst_vec = ~dst_vec; imm = ~imm; so_in = ~so_in;
        ff_en = ~ff_en; ff_excl = ~ff_excl; test_sel = ~test_sel; test_pol = ~test_pol;
        cycles = 0; writes = 0;
        while (!done && cycles < 200) begin
            if (cf_we) writes++;
            start = (poke != 0 && cycles == 1) ? 1'b1 : 1'b0;
            @(posedge clk);
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;

        check("R2", cycles == nproc, "edges from start to done", cycles, nproc);
        check("R7", writes == nproc, "element writes", writes, nproc);
        check((etr != 0) ? ((ex != 0) ? "R8" : "R7") : ((vc == 0) ? "R9" : "R2"),
              int'(vl_out) == evl, "vl_out", int'(vl_out), evl);
        check((etr != 0) ? "R6" : "R2", int'(trunc) == etr, "trunc", int'(trunc), etr);
        check("R11", !busy, "busy during done", int'(busy), 0);
        for (int j = 0; j < NCF; j++) begin
            check((dv != 0) ? "R5" : "R3", cf_mem[j] == exp_cf[j],
                  $sformatf("cf slot %0d (R4 src)", j), int'(cf_mem[j]), int'(exp_cf[j]));
        end
        @(negedge clk);
        check("R11", !done, "done after pulse", int'(done), 0);
        check("R11", int'(vl_out) == evl, "vl_out held", int'(vl_out), evl);
    endtask

    initial begin
        int runs;
        int vls [7] = '{0, 1, 3, 5, 8, 64, 100};
        for (int k = 0; k < NREG; k++) rf[k] = XLEN'(((k * 5) % 9) - 4);
        for (int j = 0; j < NCF; j++) exp_cf[j] = 4'(j * 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", !busy && !done && !cf_we, "idle flags", int'({busy, done, cf_we}), 0);
        check("R1", vl_out == '0 && !trunc, "result regs", int'(vl_out), 0);

        // R9 directed: exclusive failure at element 0 gives zero length
        rf[2] = 16'sd7;
        run(5, 2, 1, 0, 1, 7, 0, 1, 1, 1, 1, 0);
        check("R9", vl_out == '0 && trunc, "zero after exclusive first fail", int'(vl_out), 0);

        runs = 0;
        for (int vi = 0; vi < 7; vi++)
            for (int mode = 0; mode < 4; mode++)
                for (int sel = 0; sel < 4; sel++)
                    for (int pol = 0; pol < 2; pol++)
                        for (int ff = 0; ff < 2; ff++)
                            for (int ex = 0; ex < 2; ex++) begin
                                run(vls[vi], (runs * 3) % NREG, mode & 1, runs % NCF, (mode >> 1) & 1,
                                    (vi % 3) - 1, pol ^ (mode & 1), ff, ex, sel, pol, runs & 1);
                                runs++;
                            end
        finish_run();
    end
endmodule